// File: doc/BRIEF.md
# Ping-Pong Receive Buffer with DMA Request

This block holds the received data of one receive endpoint in two buffers of 64 bytes that are used in turn. The receive side streams each packet in byte by byte and marks its final byte. The block stores the packet in whichever buffer comes next in rotation and records how many bytes it holds. A packet that arrives while both buffers are occupied is thrown away and refused.

The reader, either a DMA engine or the CPU, takes bytes from the buffer that is currently selected. When software is reading, a drained buffer keeps its place until a read-done strobe releases it and hands over to the other buffer. When DMA is enabled, the block releases the buffer on its own as soon as the last stored byte is taken, for full and short packets alike. A read-done strobe given during DMA still forces a release and a switch, which is the over-transfer fault that software must avoid. An active-low request, routed to one of two lines, tells the DMA engine that data is waiting.

Top module: `rxb_pingpong_rx`

## Requirements
- R1: After reset no buffer holds data, `rd_valid` and `rx_nak` are 0 and both request lines are 1.
- R2: Packets are read back in arrival order, each byte equal to the value written, and accepted packets go into the two buffers alternately.
- R3: A buffer keeps at most 64 bytes; beats of a packet past its 64th byte are dropped, and the stored count is 64.
- R4: A packet whose first beat arrives while both buffers are occupied is discarded whole, `rx_nak` is 1 during its last beat, and the stored packets are unchanged.
- R5: With `dma_en`=0, once every stored byte of the selected buffer is read, `rd_valid` stays 0 until `rd_done` is pulsed, after which the other buffer is read.
- R6: With `dma_en`=0, an `rd_done` pulse while the selected buffer holds no packet changes nothing.
- R7: With `dma_en`=1, taking the last stored byte of the selected buffer releases it and selects the other buffer in the same clock edge, for 64-byte and shorter packets.
- R8: With `dma_en`=1, every `rd_done` pulse releases the selected buffer and selects the other one, discarding unread bytes, even when the selected buffer is empty.
- R9: The active request line is 0 exactly when `dma_en`=1 and at least one buffer holds a packet; it returns to 1 once both are empty.
- R10: `req_sel`=0 routes the request to `dreq0_n`, `req_sel`=1 to `dreq1_n`; the unused line stays 1.
- R11: `rd_valid` is 1 only while the selected buffer holds unread bytes; `rd_data` is then the byte at the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the packet |
| rx_nak | output | 1 | The packet ending this cycle was refused |
| dma_en | input | 1 | 1 selects DMA mode with automatic release |
| req_sel | input | 1 | Chooses which request line carries the request |
| rd_en | input | 1 | Take the current byte |
| rd_data | output | 8 | Byte at the read position |
| rd_valid | output | 1 | Selected buffer has an unread byte |
| rd_done | input | 1 | Software strobe releasing the selected buffer |
| dreq0_n | output | 1 | Active-low request line 0 |
| dreq1_n | output | 1 | Active-low request line 1 |

## Verification
Every cycle the assertions check the routing of the request onto one line, that the request is off whenever DMA is disabled, that readable data in DMA mode always comes with an active request, that a refusal only marks a packet's last beat, and that in software mode a drained buffer cannot become readable without a receive beat or a read-done strobe. Byte order, the 64-byte cap and the alternation between buffers are shown only by the bench's sweep over every packet length from 1 to 66. The same holds for the refusal of a third packet, the automatic release on full and short packets, and the misalignment caused by a read-done strobe in DMA mode.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned NBANK = 2;
  typedef logic bank_t;

  function automatic bank_t other_bank(bank_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/rxb_bank_state.sv
module rxb_bank_state
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  bank_t                       wr_bank,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic                        set_en,
  input  bank_t                       set_bank,
  input  logic [CW-1:0]               set_cnt,
  input  logic                        clr_en,
  input  bank_t                       clr_bank,
  input  bank_t                       rd_bank,
  input  logic [AW-1:0]               rd_addr,
  output logic [NBANK-1:0]            full_o,
  output logic [NBANK-1:0][CW-1:0]    cnt_o,
  output logic [DW-1:0]               rd_data
);
  logic [DW-1:0] rdata [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam bank_t ID = bank_t'(b);
    logic [DW-1:0] mem [DEPTH];
    logic          full_q, full_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit_set, hit_clr, hit_wr;

    assign hit_set = set_en && (set_bank == ID);
    assign hit_clr = clr_en && (clr_bank == ID);
    assign hit_wr  = wr_en  && (wr_bank  == ID);

    // commit wins over a simultaneous release of the same bank
    always_comb begin
      full_d = full_q;
      cnt_d  = cnt_q;
      if (hit_clr) full_d = 1'b0;
      if (hit_set) begin
        full_d = 1'b1;
        cnt_d  = set_cnt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        full_q <= full_d;
        if (hit_set) cnt_q <= cnt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) mem[wr_addr] <= wr_data;
    end

    assign full_o[b] = full_q;
    assign cnt_o[b]  = cnt_q;
    assign rdata[b]  = mem[rd_addr];
  end

  assign rd_data = rdata[rd_bank];
endmodule

// File: rtl/rxb_write_ctrl.sv
module rxb_write_ctrl
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_last,
  input  logic [NBANK-1:0] full_i,
  output logic             rx_nak,
  output logic             wr_en,
  output bank_t            wr_bank,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             set_en,
  output bank_t            set_bank,
  output logic [CW-1:0]    set_cnt
);
  bank_t         fill_q, fill_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic          inpkt_q, inpkt_d;
  logic          drop_q, drop_d;
  logic          dropping, space;

  always_comb begin
    dropping = inpkt_q ? drop_q : full_i[fill_q];
    space    = ptr_q < CW'(DEPTH);
    wr_en    = rx_valid && !dropping && space;
    wr_bank  = fill_q;
    wr_addr  = ptr_q[AW-1:0];
    wr_data  = rx_data;
    set_en   = rx_valid && rx_last && !dropping;
    set_bank = fill_q;
    set_cnt  = space ? ptr_q + CW'(1) : ptr_q;
    rx_nak   = rx_valid && rx_last && dropping;

    fill_d  = fill_q;
    ptr_d   = ptr_q;
    inpkt_d = inpkt_q;
    drop_d  = drop_q;
    if (rx_valid) begin
      inpkt_d = !rx_last;
      drop_d  = rx_last ? 1'b0 : dropping;
      if (rx_last)    ptr_d = '0;
      else if (wr_en) ptr_d = ptr_q + CW'(1);
      if (set_en)     fill_d = other_bank(fill_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= 1'b0;
      ptr_q   <= '0;
      inpkt_q <= 1'b0;
      drop_q  <= 1'b0;
    end else if (rx_valid) begin
      fill_q  <= fill_d;
      ptr_q   <= ptr_d;
      inpkt_q <= inpkt_d;
      drop_q  <= drop_d;
    end
  end
endmodule

// File: rtl/rxb_read_ctrl.sv
module rxb_read_ctrl
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dma_en,
  input  logic                     rd_en,
  input  logic                     rd_done,
  input  logic [NBANK-1:0]         full_i,
  input  logic [NBANK-1:0][CW-1:0] cnt_i,
  output bank_t                    rd_bank,
  output logic [AW-1:0]            rd_addr,
  output logic                     rd_valid,
  output logic                     clr_en,
  output bank_t                    clr_bank
);
  bank_t         sel_q, sel_d;
  logic [CW-1:0] ptr_q, ptr_d, ptr_inc, cur_cnt;
  logic          cur_full, avail, take, drained, release_now;

  always_comb begin
    cur_full    = full_i[sel_q];
    cur_cnt     = cnt_i[sel_q];
    avail       = cur_full && (ptr_q < cur_cnt);
    take        = rd_en && avail;
    ptr_inc     = ptr_q + CW'(1);
    drained     = take && (ptr_inc == cur_cnt);
    release_now = dma_en ? (drained || rd_done) : (rd_done && cur_full);

    sel_d = sel_q;
    ptr_d = ptr_q;
    if (release_now) begin
      sel_d = other_bank(sel_q);
      ptr_d = '0;
    end else if (take) begin
      ptr_d = ptr_inc;
    end
  end

  assign rd_bank  = sel_q;
  assign rd_addr  = ptr_q[AW-1:0];
  assign rd_valid = avail;
  assign clr_en   = release_now;
  assign clr_bank = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ptr_q <= '0;
    end else if (release_now || take) begin
      sel_q <= sel_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/rxb_pingpong_rx.sv
module rxb_pingpong_rx
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  output logic          rx_nak,
  input  logic          dma_en,
  input  logic          req_sel,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_done,
  output logic          dreq0_n,
  output logic          dreq1_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [1:0]               rst_sync;
  logic                     rst_ni;
  logic                     wr_en, set_en, clr_en;
  bank_t                    wr_bank, set_bank, clr_bank, rd_bank;
  logic [AW-1:0]            wr_addr, rd_addr;
  logic [DW-1:0]            wr_data;
  logic [CW-1:0]            set_cnt;
  logic [NBANK-1:0]         full;
  logic [NBANK-1:0][CW-1:0] cnt;
  logic                     req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  rxb_write_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk, .rst_n(rst_ni), .rx_valid, .rx_data, .rx_last, .full_i(full),
    .rx_nak, .wr_en, .wr_bank, .wr_addr, .wr_data,
    .set_en, .set_bank, .set_cnt
  );

  rxb_bank_state #(.DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk, .rst_n(rst_ni), .wr_en, .wr_bank, .wr_addr, .wr_data,
    .set_en, .set_bank, .set_cnt, .clr_en, .clr_bank,
    .rd_bank, .rd_addr, .full_o(full), .cnt_o(cnt), .rd_data
  );

  rxb_read_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk, .rst_n(rst_ni), .dma_en, .rd_en, .rd_done,
    .full_i(full), .cnt_i(cnt), .rd_bank, .rd_addr, .rd_valid,
    .clr_en, .clr_bank
  );

  assign req_n   = !(dma_en && (|full));
  assign dreq0_n = req_sel ? 1'b1  : req_n;
  assign dreq1_n = req_sel ? req_n : 1'b1;
endmodule

// File: rtl/rxb_pingpong_rx_chk.sv
module rxb_pingpong_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_en,
  input logic req_sel,
  input logic rx_valid,
  input logic rx_last,
  input logic rx_nak,
  input logic rd_valid,
  input logic rd_done,
  input logic dreq0_n,
  input logic dreq1_n
);
  p_unused_line0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_sel |-> dreq0_n);
  p_unused_line1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_sel |-> dreq1_n);
  p_off_without_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> (dreq0_n && dreq1_n));
  p_data_raises_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && rd_valid) |-> (req_sel ? !dreq1_n : !dreq0_n));
  p_nak_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nak |-> (rx_valid && rx_last));
  p_sw_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !rd_valid && !rd_done && !rx_valid) |=> !rd_valid);
endmodule

bind rxb_pingpong_rx rxb_pingpong_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .req_sel(req_sel),
  .rx_valid(rx_valid), .rx_last(rx_last), .rx_nak(rx_nak),
  .rd_valid(rd_valid), .rd_done(rd_done),
  .dreq0_n(dreq0_n), .dreq1_n(dreq1_n)
);

// File: tb/sim_rxb_pingpong_rx.sv
`timescale 1ns/1ps
module sim_rxb_pingpong_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_last = 1'b0, rx_nak;
  logic [7:0] rx_data = '0, rd_data;
  logic       dma_en = 1'b0, req_sel = 1'b0, rd_en = 1'b0, rd_done = 1'b0;
  logic       rd_valid, dreq0_n, dreq1_n;
  int         checks = 0, fails = 0;
  bit         nak;

  always #4 clk = ~clk;

  rxb_pingpong_rx u0 (
    .clk, .rst_n, .rx_valid, .rx_data, .rx_last, .rx_nak, .dma_en, .req_sel,
    .rd_en, .rd_data, .rd_valid, .rd_done, .dreq0_n, .dreq1_n
  );

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 37 + i * 5 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_valid = 0; rx_last = 0; rd_en = 0; rd_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int seed, input int len, output bit nak_seen);
    nak_seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = pat(seed, i);
      rx_last  = (i == len - 1);
      #1;
      if (rx_nak) nak_seen = 1;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic read_n(input int seed, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rd_valid && rd_data == pat(seed, i), req,
            {rd_valid, rd_data}, {1'b1, pat(seed, i)});
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check(!rd_valid, "R1 rd_valid", rd_valid, 0);
    check(!rx_nak, "R1 rx_nak", rx_nak, 0);
    check(dreq0_n && dreq1_n, "R1 dreq", {dreq0_n, dreq1_n}, 3);

    // R2 R3 R5: software-mode sweep over every length 1..66
    for (int len = 1; len <= 66; len++) begin
      send(len, len, nak);
      check(!nak, "R4 no refusal when free", nak, 0);
      check(dreq0_n && dreq1_n, "R9 no request without dma", {dreq0_n, dreq1_n}, 3);
      read_n(len, (len > 64) ? 64 : len, (len > 64) ? "R3 capped data" : "R2 data");
      check(!rd_valid, "R5 stall after drain", rd_valid, 0);
      @(negedge clk);
      check(!rd_valid, "R5 still stalled", rd_valid, 0);
      pulse_done();
      check(!rd_valid, "R11 nothing left", rd_valid, 0);
    end

    // R6: read-done on empty selection is ignored in software mode
    pulse_done();
    send(200, 4, nak);
    read_n(200, 4, "R6 selection unchanged");
    pulse_done();

    // R4: third packet refused while both full
    do_reset();
    send(1, 10, nak);
    check(!nak, "R4 first accepted", nak, 0);
    send(2, 12, nak);
    check(!nak, "R4 second accepted", nak, 0);
    send(3, 5, nak);
    check(nak, "R4 third refused", nak, 1);
    read_n(1, 10, "R2 first packet");
    pulse_done();
    read_n(2, 12, "R4 stored data intact");
    pulse_done();
    check(!rd_valid, "R4 refused packet not stored", rd_valid, 0);
    send(4, 3, nak);
    check(!nak, "R4 accepted after drain", nak, 0);
    read_n(4, 3, "R2 after refusal");
    pulse_done();

    // R7 R9 R10: DMA mode, 64 + 64 + 22 bytes
    do_reset();
    dma_en = 1'b1; req_sel = 1'b0;
    @(negedge clk);
    check(dreq0_n && dreq1_n, "R9 idle high", {dreq0_n, dreq1_n}, 3);
    send(10, 64, nak);
    check(!dreq0_n && dreq1_n, "R10 line0 active", {dreq0_n, dreq1_n}, 1);
    send(11, 64, nak);
    read_n(10, 64, "R7 first full packet");
    check(rd_valid && rd_data == pat(11, 0), "R7 auto switch", {rd_valid, rd_data}, {1'b1, pat(11, 0)});
    check(!dreq0_n, "R9 one buffer left", dreq0_n, 0);
    read_n(11, 64, "R7 second full packet");
    check(dreq0_n, "R9 both empty", dreq0_n, 1);
    check(!rd_valid, "R11 empty after dma", rd_valid, 0);
    send(12, 22, nak);
    check(!dreq0_n, "R9 short packet request", dreq0_n, 0);
    read_n(12, 22, "R7 short packet");
    check(dreq0_n, "R7 short packet released", dreq0_n, 1);

    // R10: second request line
    req_sel = 1'b1;
    send(20, 7, nak);
    check(dreq0_n && !dreq1_n, "R10 line1 active", {dreq0_n, dreq1_n}, 2);
    read_n(20, 7, "R10 data");
    check(dreq1_n, "R9 line1 released", dreq1_n, 1);
    req_sel = 1'b0;

    // R8: read-done during DMA forces extra release
    send(30, 10, nak);
    send(31, 5, nak);
    read_n(30, 3, "R8 partial read");
    pulse_done();
    check(rd_valid && rd_data == pat(31, 0), "R8 unread bytes discarded",
          {rd_valid, rd_data}, {1'b1, pat(31, 0)});
    read_n(31, 5, "R8 next packet");
    check(dreq0_n, "R9 drained", dreq0_n, 1);
    pulse_done();
    send(32, 6, nak);
    check(!rd_valid, "R8 misaligned selection", rd_valid, 0);
    check(!dreq0_n, "R9 request with misaligned data", dreq0_n, 0);
    dma_en = 1'b0;
    #1;
    check(dreq0_n && dreq1_n, "R9 dma off drops request", {dreq0_n, dreq1_n}, 3);
    dma_en = 1'b1;
    #1;
    check(!dreq0_n, "R9 dma on restores request", dreq0_n, 0);
    pulse_done();
    read_n(32, 6, "R8 realigned");
    check(dreq0_n, "R9 final empty", dreq0_n, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule